// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a clocked, single-port memory model with byte lanes. It behaves like a flow-through synchronous static RAM with no wait states. Every control input is sampled on the rising clock edge, but only when the active-low clock enable is low. Holding the clock enable high stretches the current cycle without ending the access. Read data is not registered. It comes from the address captured at the last accepted edge and is valid before the next edge.

An access begins with a load cycle, where `step_load` is low. On that edge the address, the three select lines, the write control and the lane strobes are taken. Later cycles with `step_load` high walk a 2-bit burst counter through the low two address bits. The order is linear or interleaved, chosen by a static strap. Write data follows its address by one accepted edge.

The data bus is split into `wdata`, `rdata` and a drive flag. These stand in for a shared bidirectional bus. Several rules keep the output undriven during cycles that must not carry read data. A sleep input freezes the block and hides its outputs. The array contents are kept while asleep.

The default depth is 1024 words so that the array stays small at elaboration. Setting `ADDR_W` to 16 gives the full 65,536-word configuration.

Top module: `burst_sram_model`

## Requirements
- R1: After reset no access is in progress, and `rdata_drive` is 0 with `rdata` all zero.
- R2: A load edge starts an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination deselects the block, and the output stays undriven whatever `rd_en_n` is.
- R3: After a read load edge, `rdata` shows the word at the loaded address before the next rising edge, with no extra register stage. A read started straight from the deselected state is subject to R10.
- R4: For a write (`wr_n`=0 on the load edge), `wdata` is captured on the next accepted edge. A lane `i` is written only if `lane_wr_n[i]` was 0 on the address edge; that lane is bits 8i+7..8i. All other lanes keep their old contents.
- R5: A read whose load edge is the edge that captures the preceding write's data returns the newly written bytes.
- R6: With `order_sel`=0, burst beat k (k = 0..3) uses low address bits (b+k) mod 4, where b is the loaded low pair. The upper address bits never change during a burst.
- R7: With `order_sel`=1, burst beat k uses the low address bits b XOR k.
- R8: A rising edge with `clk_en_n`=1 is ignored. The address, the burst position, the access type and any pending write data capture are all held, and the block stays selected.
- R9: An advance cycle (`step_load`=1) while deselected leaves the block deselected. Only a selected load cycle restarts access.
- R10: `rdata_drive` is 1 only during a read beat while `rd_en_n`=0. It is 0 in these cases:
  - during a write data cycle;
  - in the first cycle after leaving the deselected state;
  - while deselected.

  `rdata` is zero whenever `rdata_drive` is 0.
- R11: While `sleep_req`=1, edges are ignored and `rdata_drive` is 0. When sleep ends, the array contents and the access state are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low qualifier for the rising edge |
| sel_a_n | input | 1 | Select line, active low |
| sel_b | input | 1 | Select line, active high |
| sel_c_n | input | 1 | Select line, active low |
| wr_n | input | 1 | Active-low write request, sampled on a load edge |
| lane_wr_n | input | LANES | Active-low byte-lane write strobes |
| step_load | input | 1 | 1 = advance the burst, 0 = load a new address |
| addr | input | ADDR_W | Word address |
| order_sel | input | 1 | Burst order strap: 0 = linear, 1 = interleaved |
| sleep_req | input | 1 | Sleep: freeze the block and hide its outputs |
| rd_en_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | 8*LANES | Write data |
| rdata | output | 8*LANES | Read data, zero while not driven |
| rdata_drive | output | 1 | High when the data bus would be driven |

## Verification
Read data is due in the same cycle as its load or advance edge, because the array read is combinational from the captured address. The bench therefore drives each cycle's inputs on the falling edge and compares outputs on the next falling edge. Write data is due one accepted edge after its address. The bench presents it with the following cycle's inputs and re-presents it across stretched cycles, so the reference memory is updated only on the edge that really captures it. The reference tracks every byte lane that has been written and compares only those lanes. Edges masked by clock enable or by sleep leave both the reference state and the expected outputs unchanged.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address pair for a burst beat: linear adds, interleaved XORs.
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       interleave);
    logic [1:0] r;
    if (interleave) r = base ^ cnt;
    else            r = base + cnt;
    return r;
  endfunction

endpackage

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_load,
  input  logic              do_step,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] cur_addr
);
  import bsram_pkg::*;

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      base_q, base_d;
  logic [1:0]      cnt_q, cnt_d;

  always_comb begin
    hi_d   = hi_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (do_load) begin
      hi_d   = addr_in[ADDR_W-1:2];
      base_d = addr_in[1:0];
      cnt_d  = 2'd0;
    end else if (do_step) begin
      cnt_d  = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      hi_q   <= hi_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_addr = {hi_q, beat_low(base_q, cnt_q, order_sel)};

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_ok,
  input  logic             step_load,
  input  logic             sel_ok,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output bsram_pkg::op_e   op_q,
  output logic             first_q,
  output logic             do_load,
  output logic             do_step,
  output logic             mem_we,
  output logic [LANES-1:0] mem_be
);
  import bsram_pkg::*;

  op_e              op_d;
  logic             first_d;
  logic [LANES-1:0] lanes_q, lanes_d;

  assign do_load = edge_ok && !step_load;
  assign do_step = edge_ok && step_load && (op_q != OP_IDLE);

  always_comb begin
    op_d    = op_q;
    first_d = first_q;
    lanes_d = lanes_q;
    if (do_load) begin
      lanes_d = lane_wr_n;
      if (sel_ok) begin
        op_d    = wr_n ? OP_READ : OP_WRITE;
        first_d = (op_q == OP_IDLE);
      end else begin
        op_d    = OP_IDLE;
        first_d = 1'b0;
      end
    end else if (do_step) begin
      lanes_d = lane_wr_n;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      first_q <= 1'b0;
      lanes_q <= '1;
    end else begin
      op_q    <= op_d;
      first_q <= first_d;
      lanes_q <= lanes_d;
    end
  end

  // The edge that closes a write address cycle is the one that takes its data.
  assign mem_we = edge_ok && (op_q == OP_WRITE);
  assign mem_be = ~lanes_q;

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [LANES-1:0]     be,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*LANES-1:0]   wdata,
  output logic [8*LANES-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && be[l]) mem[addr] <= wdata[8*l +: 8];
    end

    assign rdata[8*l +: 8] = mem[addr];
  end

endmodule

// File: rtl/bsram_outgate.sv
module bsram_outgate #(
  parameter int DATA_W = 32
) (
  input  bsram_pkg::op_e    op_q,
  input  logic              first_q,
  input  logic              rd_en_n,
  input  logic              sleep_req,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drive
);
  import bsram_pkg::*;

  assign rdata_drive = !rd_en_n && !sleep_req && (op_q == OP_READ) && !first_q;
  assign rdata       = rdata_drive ? word : '0;

endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en_n,
  input  logic                 sel_a_n,
  input  logic                 sel_b,
  input  logic                 sel_c_n,
  input  logic                 wr_n,
  input  logic [LANES-1:0]     lane_wr_n,
  input  logic                 step_load,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 order_sel,
  input  logic                 sleep_req,
  input  logic                 rd_en_n,
  input  logic [8*LANES-1:0]   wdata,
  output logic [8*LANES-1:0]   rdata,
  output logic                 rdata_drive
);
  import bsram_pkg::*;

  localparam int DATA_W = 8 * LANES;

  // Reset asserts at once and releases on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              edge_ok;
  logic              sel_ok;
  op_e               op_q;
  logic              first_q;
  logic              do_load;
  logic              do_step;
  logic              mem_we;
  logic [LANES-1:0]  mem_be;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] word;

  assign edge_ok = !clk_en_n && !sleep_req;
  assign sel_ok  = !sel_a_n && sel_b && !sel_c_n;

  bsram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .edge_ok   (edge_ok),
    .step_load (step_load),
    .sel_ok    (sel_ok),
    .wr_n      (wr_n),
    .lane_wr_n (lane_wr_n),
    .op_q      (op_q),
    .first_q   (first_q),
    .do_load   (do_load),
    .do_step   (do_step),
    .mem_we    (mem_we),
    .mem_be    (mem_be)
  );

  bsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .do_load   (do_load),
    .do_step   (do_step),
    .addr_in   (addr),
    .order_sel (order_sel),
    .cur_addr  (cur_addr)
  );

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .be    (mem_be),
    .addr  (cur_addr),
    .wdata (wdata),
    .rdata (word)
  );

  bsram_outgate #(.DATA_W(DATA_W)) u_out (
    .op_q        (op_q),
    .first_q     (first_q),
    .rd_en_n     (rd_en_n),
    .sleep_req   (sleep_req),
    .word        (word),
    .rdata       (rdata),
    .rdata_drive (rdata_drive)
  );

endmodule

// File: rtl/bsram_checker.sv
module bsram_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              sleep_req,
  input logic              step_load,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              rd_en_n,
  input logic              rdata_drive,
  input logic [1:0]        op_q,
  input logic              first_q,
  input logic [ADDR_W-1:0] cur_addr
);
  logic acc;
  assign acc = !clk_en_n && !sleep_req;

  AST_SEL_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !step_load && !(!sel_a_n && sel_b && !sel_c_n)) |=> (op_q == 2'd0)); // R2

  AST_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_load) |=> $stable(cur_addr[ADDR_W-1:2])); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n || sleep_req) |=> ($stable(op_q) && $stable(first_q))); // R8

  AST_DESEL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_load && op_q == 2'd0) |=> (op_q == 2'd0)); // R9

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 2'd2) |-> !rdata_drive); // R10

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |-> !rdata_drive); // R10

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !rdata_drive); // R11

endmodule

bind burst_sram_model bsram_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en_n    (clk_en_n),
  .sleep_req   (sleep_req),
  .step_load   (step_load),
  .sel_a_n     (sel_a_n),
  .sel_b       (sel_b),
  .sel_c_n     (sel_c_n),
  .rd_en_n     (rd_en_n),
  .rdata_drive (rdata_drive),
  .op_q        (op_q),
  .first_q     (first_q),
  .cur_addr    (cur_addr)
);

// File: tb/burst_sram_model_bench.sv
module burst_sram_model_bench;
  localparam int AW = 10;
  localparam int LN = 4;
  localparam int DW = 8 * LN;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n, sel_a_n, sel_b, sel_c_n, wr_n, step_load;
  logic [LN-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic          order_sel, sleep_req, rd_en_n;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_drive;

  always #2 clk = ~clk;

  burst_sram_model #(.ADDR_W(AW), .LANES(LN)) u_burst_sram_model (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .step_load(step_load), .addr(addr), .order_sel(order_sel),
    .sleep_req(sleep_req), .rd_en_n(rd_en_n), .wdata(wdata),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state, built from the requirements.
  logic [DW-1:0] ref_mem [DEPTH];
  logic [LN-1:0] ref_vld [DEPTH];
  int            m_op;      // 0 idle, 1 read, 2 write
  bit            m_first;
  logic [AW-3:0] m_hi;
  logic [1:0]    m_base, m_cnt;
  logic [LN-1:0] m_be;

  function automatic logic [AW-1:0] ref_addr();
    logic [1:0] lo;
    lo = order_sel ? (m_base ^ m_cnt) : (m_base + m_cnt);
    return {m_hi, lo};
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [LN-1:0] v);
    logic [DW-1:0] m;
    for (int l = 0; l < LN; l++) m[8*l +: 8] = {8{v[l]}};
    return m;
  endfunction

  task automatic check(input string tag);
    logic          exp_drv;
    logic [DW-1:0] exp_d, msk;
    exp_drv = !rd_en_n && !sleep_req && (m_op == 1) && !m_first;
    n_vec++;
    if (rdata_drive !== exp_drv) begin
      n_bad++;
      $display("FAIL %s drive actual=%0b expected=%0b", tag, rdata_drive, exp_drv);
    end else if (!exp_drv) begin
      if (rdata !== '0) begin
        n_bad++;
        $display("FAIL %s idle data actual=%h expected=%h", tag, rdata, {DW{1'b0}});
      end
    end else begin
      msk   = lane_mask(ref_vld[ref_addr()]);
      exp_d = ref_mem[ref_addr()] & msk;
      if ((rdata & msk) !== exp_d) begin
        n_bad++;
        $display("FAIL %s data actual=%h expected=%h", tag, rdata & msk, exp_d);
      end
    end
  endtask

  // One cycle: drive at the falling edge, let the rising edge act,
  // update the reference, then compare at the next falling edge.
  // desel: 0 selected, 1/2/3 break one select line.
  task automatic step(input string tag, input bit cen, input int desel,
                      input bit we, input bit adv, input int a,
                      input logic [LN-1:0] be, input logic [DW-1:0] d,
                      input bit oe, input bit slp);
    clk_en_n  = cen;
    sel_a_n   = (desel == 1);
    sel_b     = (desel != 2);
    sel_c_n   = (desel == 3);
    wr_n      = we;
    step_load = adv;
    addr      = a[AW-1:0];
    lane_wr_n = be;
    wdata     = d;
    rd_en_n   = oe;
    sleep_req = slp;
    @(posedge clk);
    if (!cen && !slp) begin
      if (m_op == 2) begin
        for (int l = 0; l < LN; l++)
          if (!m_be[l]) begin
            ref_mem[ref_addr()][8*l +: 8] = d[8*l +: 8];
            ref_vld[ref_addr()][l] = 1'b1;
          end
      end
      if (!adv) begin
        m_hi = a[AW-1:2]; m_base = a[1:0]; m_cnt = 2'd0; m_be = be;
        if (desel == 0) begin
          m_first = (m_op == 0);
          m_op = we ? 1 : 2;
        end else begin
          m_op = 0; m_first = 0;
        end
      end else if (m_op != 0) begin
        m_cnt = m_cnt + 2'd1; m_first = 0; m_be = be;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd20250611;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) begin ref_vld[i] = '0; ref_mem[i] = '0; end
    m_op = 0; m_first = 0; m_hi = '0; m_base = '0; m_cnt = '0; m_be = '1;
    clk_en_n = 1; sel_a_n = 1; sel_b = 0; sel_c_n = 1; wr_n = 1; step_load = 0;
    addr = '0; lane_wr_n = '1; wdata = '0; order_sel = 0; sleep_req = 0; rd_en_n = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1");  // reset state: nothing driven

    // R4 write all lanes then R5 read back on the capture edge
    step("R4", 0, 0, 0, 0, 'h10, 4'b0000, 32'h0, 0, 0);
    step("R5", 0, 0, 1, 0, 'h10, 4'b1111, 32'hA1B2C3D4, 0, 0);
    // R4 masked write: lanes 0 and 2 only (lane_wr_n=1010)
    step("R4", 0, 0, 0, 0, 'h10, 4'b1010, 32'h0, 0, 0);
    step("R4", 0, 0, 1, 0, 'h10, 4'b1111, 32'h11223344, 0, 0);
    step("R3", 0, 0, 1, 1, 'h0, 4'b1111, 32'h0, 0, 0);

    // R6 linear write burst from base 3 then read it back (3,0,1,2)
    order_sel = 0;
    step("R6", 0, 0, 0, 0, 'h23, 4'b0000, 32'h0, 0, 0);
    for (int k = 1; k < 4; k++) step("R6", 0, 0, 0, 1, 0, 4'b0000, 32'hC0DE0000 + k, 0, 0);
    step("R6", 0, 0, 1, 0, 'h23, 4'b1111, 32'hC0DE0004, 0, 0);
    for (int k = 1; k < 4; k++) step("R6", 0, 0, 1, 1, 0, 4'b1111, 32'h0, 0, 0);

    // R7 interleaved reads from base 2 and base 1 over the same row
    order_sel = 1;
    step("R7", 0, 0, 1, 0, 'h22, 4'b1111, 32'h0, 0, 0);
    for (int k = 1; k < 4; k++) step("R7", 0, 0, 1, 1, 0, 4'b1111, 32'h0, 0, 0);
    step("R7", 0, 0, 1, 0, 'h21, 4'b1111, 32'h0, 0, 0);
    for (int k = 1; k < 4; k++) step("R7", 0, 0, 1, 1, 0, 4'b1111, 32'h0, 0, 0);
    order_sel = 0;

    // R8 stretched write data phase: data on masked edges is dropped
    step("R8", 0, 0, 0, 0, 'h30, 4'b0000, 32'h0, 0, 0);
    step("R8", 1, 0, 1, 0, 'h31, 4'b0000, 32'hDEADDEAD, 0, 0);
    step("R8", 1, 1, 1, 0, 'h32, 4'b0000, 32'hBADBAD00, 0, 0);
    step("R8", 0, 0, 1, 0, 'h30, 4'b1111, 32'h5A5A0F0F, 0, 0);
    step("R8", 1, 0, 1, 0, 'h10, 4'b1111, 32'h0, 0, 0);

    // R2 each broken select line deselects even with output enabled
    step("R2", 0, 1, 1, 0, 'h10, 4'b1111, 32'h0, 0, 0);
    step("R2", 0, 2, 1, 0, 'h10, 4'b1111, 32'h0, 0, 0);
    step("R2", 0, 3, 1, 0, 'h10, 4'b1111, 32'h0, 0, 0);
    // R9 advance while deselected stays deselected
    step("R9", 0, 0, 1, 1, 'h10, 4'b1111, 32'h0, 0, 0);
    // R10 first read beat after deselect hidden, next beat driven
    step("R10", 0, 0, 1, 0, 'h23, 4'b1111, 32'h0, 0, 0);
    step("R10", 0, 0, 1, 1, 0, 4'b1111, 32'h0, 0, 0);
    step("R10", 0, 0, 1, 1, 0, 4'b1111, 32'h0, 1, 0);

    // R11 sleep: write attempt ignored, output hidden, state kept
    step("R11", 0, 0, 0, 0, 'h10, 4'b0000, 32'h0, 0, 1);
    step("R11", 0, 0, 1, 0, 'h10, 4'b0000, 32'hFFFFFFFF, 0, 1);
    step("R11", 0, 0, 1, 0, 'h10, 4'b1111, 32'h0, 0, 0);

    // Random traffic over a small window; R3 is the main read path.
    for (int i = 0; i < 4000; i++) begin
      int r, ds;
      r  = $urandom_range(99);
      ds = ($urandom_range(9) == 0) ? $urandom_range(3) : 0;
      if (i == 2000) order_sel = 1;
      step("R3", ($urandom_range(7) == 0), ds, $urandom_range(1), (r < 55),
           $urandom_range(63), 4'($urandom), $urandom,
           ($urandom_range(9) == 0), ($urandom_range(24) == 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule